// File: doc/BRIEF.md
# Branch Trace Record Queue

This block holds a short history of taken branches for a debugger. Whenever the core reports a branch, the block stores one record made of a flag word, the address the branch left from and the address it went to. Up to four records are kept, oldest first. When a fifth arrives the oldest one is dropped and a sticky overflow flag records the loss.

Software drains the history through a small register read bus with three ports: flags at offset 0x0, source address at offset 0x4 and destination address at offset 0x8. Every port shows the oldest record. To fetch one record, software reads the flag port, then the source port, then the destination port. The destination read is the only access that retires the record. Because of this, flag and source reads may be repeated freely, and the destination read must always come last.

Top module: `btq_top`

## Requirements
- R1: After synchronous reset, `q_empty` is 1, `q_overflow` is 0 and `rd_data` is 0.
- R2: The queue holds up to four records, and successive destination reads return them in the order in which the branches arrived.
- R3: A read at offset 0x0, of any size, returns the head flag word in bits 15:0 with zeros above. A longword read at offset 0x4 returns the head source address. Neither read changes the queue, so repeated reads return the same values.
- R4: A longword read at offset 0x8 (`rd_size` = 2'b10) returns the head destination address and removes the head record. `q_empty` rises once the last record has been removed.
- R5: A byte read (`rd_size` 2'b00), a halfword read (2'b01) or a reserved-size read (2'b11) at offset 0x4 or 0x8 returns zero and leaves the queue unchanged.
- R6: A branch event that arrives while four records are held, with no removal in the same cycle, discards the oldest record and sets `q_overflow`. The flag then stays set.
- R7: A read at offset 0x0 clears `q_overflow`, unless an overflow happens in the same cycle, in which case the flag stays set.
- R8: While the queue is empty, a read at any offset returns zero, `q_empty` is 1, and a destination read removes nothing.
- R9: A branch event and a removing destination read in the same cycle act as a removal followed by an insertion. No record is lost and no overflow is raised.
- R10: `rd_data` is registered. It takes the value of a read on the clock edge where `rd_en` is sampled and holds it while `rd_en` is low. Reads at offsets other than 0x0, 0x4 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event strobe |
| br_src | input | 32 | Address the branch was taken from |
| br_dst | input | 32 | Address the branch went to |
| br_flags | input | 16 | Flag word stored with the record |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Byte offset of the read |
| rd_size | input | 2 | Access size: 00 byte, 01 halfword, 10 longword, 11 reserved |
| rd_data | output | 32 | Registered read data |
| q_empty | output | 1 | No record is held |
| q_overflow | output | 1 | Sticky flag: a record was discarded |

## Verification
The hardest case to reach is a branch event that lands in the same cycle as a destination read while all four slots are full. It must not raise overflow, yet one cycle earlier or later the same event would discard a record. Random stimulus rarely lines these up, so directed sequences fill the queue and then issue that collision. They also issue a collision on an empty queue, and a flag read that coincides with an overflow. On top of these runs a seeded random mix of events, reads at all four offsets and all sizes, with an event rate high enough to keep the queue near full. The bench tracks the expected records and flags in its own model.

// File: rtl/btq_pkg.sv
package btq_pkg;
  localparam int unsigned OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_FLAG = 4'h0;
  localparam logic [OFS_W-1:0] OFS_SRC  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_DST  = 4'h8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } btq_size_e;
endpackage

// File: rtl/btq_store.sv
module btq_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned FW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_src,
  input  logic [AW-1:0] push_dst,
  input  logic [FW-1:0] push_flg,
  input  logic          pop,
  input  logic          ovf_clr,
  output logic [AW-1:0] head_src,
  output logic [AW-1:0] head_dst,
  output logic [FW-1:0] head_flg,
  output logic          empty,
  output logic          ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [AW-1:0] mem_src [DEPTH];
  logic [AW-1:0] mem_dst [DEPTH];
  logic [FW-1:0] mem_flg [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic full, pop_eff, drop, adv_rd;

  assign full    = (count == FULLC);
  assign empty   = (count == '0);
  assign pop_eff = pop && !empty;
  assign drop    = push && full && !pop_eff;
  assign adv_rd  = pop_eff || drop;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem_src[wr_ptr] <= push_src;
      mem_dst[wr_ptr] <= push_dst;
      mem_flg[wr_ptr] <= push_flg;
    end
  end

  assign head_src = mem_src[rd_ptr];
  assign head_dst = mem_dst[rd_ptr];
  assign head_flg = mem_flg[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (adv_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop_eff && !full) count <= count + 1'b1;
      else if (!push && pop_eff)     count <= count - 1'b1;
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
    count <= FULLC);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (ovf && full));
  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(push && full && !pop)) |=> !ovf);
  assert_swap_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> ($stable(count) && !$rose(ovf)));
endmodule

// File: rtl/btq_rdport.sv
module btq_rdport
  import btq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned FW = 16,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] rd_addr,
  input  logic [1:0]       rd_size,
  input  logic [AW-1:0]    head_src,
  input  logic [AW-1:0]    head_dst,
  input  logic [FW-1:0]    head_flg,
  input  logic             empty,
  output logic             pop,
  output logic             ovf_clr,
  output logic [DW-1:0]    rd_data
);
  logic sel_flg, sel_src, sel_dst, is_long;
  logic [DW-1:0] nxt;

  assign sel_flg = rd_en && (rd_addr == OFS_FLAG);
  assign sel_src = rd_en && (rd_addr == OFS_SRC);
  assign sel_dst = rd_en && (rd_addr == OFS_DST);
  assign is_long = (btq_size_e'(rd_size) == SZ_LONG);

  assign pop     = sel_dst && is_long && !empty;
  assign ovf_clr = sel_flg;

  always_comb begin
    nxt = '0;
    if (!empty) begin
      if (sel_flg)                nxt = DW'(head_flg);
      else if (sel_src && is_long) nxt = DW'(head_src);
      else if (sel_dst && is_long) nxt = DW'(head_dst);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end

  assert_short_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == OFS_SRC || rd_addr == OFS_DST) && !is_long) |=> (rd_data == '0));
  assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (rd_data == '0));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/btq_top.sv
module btq_top
  import btq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned FW    = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_valid,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_dst,
  input  logic [FW-1:0] br_flags,
  input  logic          rd_en,
  input  logic [3:0]    rd_addr,
  input  logic [1:0]    rd_size,
  output logic [DW-1:0] rd_data,
  output logic          q_empty,
  output logic          q_overflow
);
  logic [AW-1:0] h_src, h_dst;
  logic [FW-1:0] h_flg;
  logic do_pop, do_clr;

  btq_store #(.DEPTH(DEPTH), .AW(AW), .FW(FW)) u_store (
    .clk(clk), .rst(rst),
    .push(br_valid), .push_src(br_src), .push_dst(br_dst), .push_flg(br_flags),
    .pop(do_pop), .ovf_clr(do_clr),
    .head_src(h_src), .head_dst(h_dst), .head_flg(h_flg),
    .empty(q_empty), .ovf(q_overflow)
  );

  btq_rdport #(.AW(AW), .FW(FW), .DW(DW)) u_rdport (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .head_src(h_src), .head_dst(h_dst), .head_flg(h_flg), .empty(q_empty),
    .pop(do_pop), .ovf_clr(do_clr), .rd_data(rd_data)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (q_empty && !q_overflow && rd_data == '0));
endmodule

// File: tb/tb_btq_top.sv
module tb_btq_top;
  logic clk = 1'b0;
  logic rst;
  logic br_valid;
  logic [31:0] br_src, br_dst;
  logic [15:0] br_flags;
  logic rd_en;
  logic [3:0] rd_addr;
  logic [1:0] rd_size;
  logic [31:0] rd_data;
  logic q_empty, q_overflow;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_src[$];
  logic [31:0] m_dst[$];
  logic [15:0] m_flg[$];
  logic m_ovf;
  logic [31:0] m_data;

  always #2 clk = ~clk;

  btq_top dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .br_flags(br_flags), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_data(rd_data), .q_empty(q_empty), .q_overflow(q_overflow)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [1:0] s);
    if (m_src.size() == 0) return 32'h0;
    if (a == 4'h0) return {16'h0, m_flg[0]};
    if (a == 4'h4 && s == 2'b10) return m_src[0];
    if (a == 4'h8 && s == 2'b10) return m_dst[0];
    return 32'h0;
  endfunction

  // one clock: drive at negedge, model, check at next negedge
  task automatic step(string tag, logic ev, logic [31:0] s, logic [31:0] d,
                      logic [15:0] f, logic rd, logic [3:0] a, logic [1:0] sz);
    logic pop, setov;
    br_valid = ev; br_src = s; br_dst = d; br_flags = f;
    rd_en = rd; rd_addr = a; rd_size = sz;
    if (rd) m_data = exp_read(a, sz);
    pop = rd && a == 4'h8 && sz == 2'b10 && m_src.size() > 0;
    setov = ev && !pop && m_src.size() == 4;
    if (pop) begin
      void'(m_src.pop_front()); void'(m_dst.pop_front()); void'(m_flg.pop_front());
    end
    if (ev) begin
      if (m_src.size() == 4) begin
        void'(m_src.pop_front()); void'(m_dst.pop_front()); void'(m_flg.pop_front());
      end
      m_src.push_back(s); m_dst.push_back(d); m_flg.push_back(f);
    end
    if (rd && a == 4'h0) m_ovf = 1'b0;
    if (setov) m_ovf = 1'b1;
    @(negedge clk);
    br_valid = 1'b0; rd_en = 1'b0;
    if (rd) chk({tag, " rd_data"}, rd_data, m_data);
    chk({tag, " empty"}, {31'h0, q_empty}, {31'h0, m_src.size() == 0});
    chk({tag, " overflow"}, {31'h0, q_overflow}, {31'h0, m_ovf});
  endtask

  task automatic ev(string tag, int k);
    step(tag, 1'b1, 32'h1000_0000 + k, 32'h2000_0000 + k, 16'(16'hA000 + k), 1'b0, 4'h0, 2'b10);
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [1:0] sz);
    step(tag, 1'b0, 32'h0, 32'h0, 16'h0, 1'b1, a, sz);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; br_valid = 1'b0; br_src = '0; br_dst = '0; br_flags = '0;
    rd_en = 1'b0; rd_addr = '0; rd_size = '0; m_ovf = 1'b0; m_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 empty", {31'h0, q_empty}, 32'h1);
    chk("R1 overflow", {31'h0, q_overflow}, 32'h0);
    // R8 empty reads
    rd("R8", 4'h0, 2'b10); rd("R8", 4'h4, 2'b10); rd("R8", 4'h8, 2'b10);
    // R2 fill and drain in order, R3 repeated reads, R4 shift
    for (int i = 0; i < 4; i++) ev("R2", i);
    rd("R3", 4'h0, 2'b01); rd("R3", 4'h0, 2'b10);
    rd("R3", 4'h4, 2'b10); rd("R3", 4'h4, 2'b10);
    // R5 short reads do not shift
    rd("R5", 4'h4, 2'b00); rd("R5", 4'h8, 2'b01); rd("R5", 4'h8, 2'b11);
    // R10 unmapped and hold
    rd("R10", 4'hC, 2'b10); rd("R10", 4'h2, 2'b10);
    step("R10", 1'b0, 0, 0, 0, 1'b0, 4'h0, 2'b10);
    for (int i = 0; i < 4; i++) begin
      rd("R2", 4'h0, 2'b10); rd("R2", 4'h4, 2'b10); rd("R4", 4'h8, 2'b10);
    end
    rd("R8", 4'h8, 2'b10);
    // R6 overflow, R7 clear
    for (int i = 10; i < 16; i++) ev("R6", i);
    ev("R6", 16);
    rd("R7", 4'h0, 2'b10);
    // R7 overflow and flag read in same cycle
    step("R7", 1'b1, 32'h33, 32'h44, 16'h55, 1'b1, 4'h0, 2'b10);
    rd("R7", 4'h0, 2'b00);
    // R9 full queue: event with destination read
    step("R9", 1'b1, 32'h66, 32'h77, 16'h88, 1'b1, 4'h8, 2'b10);
    step("R9", 1'b1, 32'h69, 32'h79, 16'h89, 1'b1, 4'h8, 2'b10);
    for (int i = 0; i < 4; i++) rd("R9", 4'h8, 2'b10);
    // R9 on empty queue
    step("R9", 1'b1, 32'h91, 32'h92, 16'h93, 1'b1, 4'h8, 2'b10);
    rd("R9", 4'h8, 2'b10);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic e, r;
      logic [3:0] a;
      logic [1:0] sz;
      e = ($urandom % 100) < 45;
      r = ($urandom % 100) < 60;
      a = 4'(($urandom % 4) * 4);
      sz = (($urandom % 4) == 0) ? 2'($urandom) : 2'b10;
      step("R2", e, $urandom, $urandom, 16'($urandom), r, a, sz);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule